// File: doc/BRIEF.md
# Wide Multi-Mode Word Shifter

A purely combinational shifter that moves a word of `W` bits (a multiple of 4) by 0 to `2^AW - 1` places, toward the most significant bit or toward the least significant bit. The datapath is built from 4-bit shifter slices. Each slice moves its nibble by 0 to 3 places and takes up to three bits from the slice below it.

Larger distances come from banks of slices. Bank `b` sees the word already displaced by `4*b` places through fixed wiring. The upper bits of the shift amount decode into one enable per bank. The banks share one output bus, and only the enabled bank puts a value on it.

A two-bit mode chooses what enters the vacated end. Logical mode fills with zeros. Arithmetic mode repeats the sign bit when shifting down. Rotate mode feeds the bits that leave one end back in at the other. Downward shifts reuse the upward datapath by reversing the bit order on the way in and on the way out.

Top module: `shf_wide_top`

## Requirements
- R1: With `dir_down`=0 in logical mode, output bit i equals input bit i-k for i >= k, and the k lowest output bits are 0 (k = `amount`).
- R2: With `dir_down`=1 in logical mode, output bit i equals input bit i+k for i+k < W, and the k highest output bits are 0.
- R3: With `dir_down`=1 in arithmetic mode, the result equals the input shifted down by k, with input bit W-1 copied into the k highest output bits.
- R4: With `dir_down`=0 in arithmetic mode, the result is the same as a logical upward shift (zeros enter at bit 0).
- R5: In rotate mode, amount k rotates the word by exactly k places for every k from 0 to 2^AW-1. Upward: output bit i = input bit (i-k) mod W. Downward: output bit i = input bit (i+k) mod W.
- R6: The `mode` encoding is 2'b00 logical, 2'b01 arithmetic, 2'b10 rotate. The reserved code 2'b11 behaves exactly as logical.
- R7: When `amount` is 0, `data_out` equals `data_in` in every mode and in both directions.
- R8: Exactly one bank enable is active for every amount: the bank whose index equals `amount[AW-1:2]`. Results on both sides of every multiple of 4 follow R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | W | Word to be shifted |
| amount | input | AW | Shift distance in places |
| mode | input | 2 | Fill policy: 00 logical, 01 arithmetic, 10 rotate, 11 reserved (logical) |
| dir_down | input | 1 | 0 shifts toward bit W-1, 1 shifts toward bit 0 |
| data_out | output | W | Shifted word |

## Verification
The assertions are evaluated combinationally. They assume every input carries a known 0/1 value, and they skip evaluation while any input is unknown. They also assume `AW` is at least 3, so that a bank select field exists. The bench meets these conditions by driving every input from the first step, including during reset. It then sweeps all four mode codes, both directions and every amount, over fixed and pseudo-random data, so every bank enable is exercised with defined values.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ARITH = 2'b01,
        MODE_ROT   = 2'b10,
        MODE_RSVD  = 2'b11
    } fill_mode_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10
    } fill_src_e;

    // Resolve the requested mode and direction into what enters the vacated end.
    function automatic fill_src_e resolve_fill(fill_mode_e m, logic dn);
        fill_src_e r;
        case (m)
            MODE_ROT:   r = FILL_WRAP;
            MODE_ARITH: r = dn ? FILL_SIGN : FILL_ZERO;
            default:    r = FILL_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/shf_slice4.sv
module shf_slice4 (
    input  logic [3:0] din,
    input  logic [2:0] link,   // link[0] is the bit just below din[0]
    input  logic [1:0] sel,
    output logic [3:0] dout
);
    logic [6:0] ext;

    assign ext = {din, link[0], link[1], link[2]};

    always_comb begin
        for (int n = 0; n < 4; n++) begin
            dout[n] = ext[3'(n + 3) - 3'(sel)];
        end
    end
endmodule

// File: rtl/shf_fill.sv
module shf_fill
    import shf_pkg::*;
#(
    parameter int W  = 16,
    parameter int FW = 15
) (
    input  logic [W-1:0]  word,
    input  logic          sign_bit,
    input  fill_src_e     src,
    output logic [FW-1:0] lowfill  // lowfill[FW-1] sits directly below word[0]
);
    for (genvar m = 0; m < FW; m++) begin : g_fill
        localparam int SRCI = (((W - 1 - m) % W) + W) % W;
        assign lowfill[FW-1-m] = (src == FILL_WRAP) ? word[SRCI] :
                                 (src == FILL_SIGN) ? sign_bit   : 1'b0;
    end
endmodule

// File: rtl/shf_bank.sv
module shf_bank #(
    parameter int W  = 16,
    parameter int FW = 15,
    parameter int B  = 0
) (
    input  logic [W-1:0]  word,
    input  logic [FW-1:0] lowfill,
    input  logic [1:0]    sel,
    input  logic          en,
    output logic [W-1:0]  bus
);
    localparam int OFS = 4 * B;
    localparam int NS  = W / 4;
    localparam int LO  = FW - 3 - OFS;

    logic [W+FW-1:0] cat;
    logic [W+2:0]    pre;    // pre[2:0] feed the bottom slice's links
    logic [W-1:0]    sh;
    logic            unused_bits;

    assign cat = {word, lowfill};
    assign pre = cat[LO + W + 2 : LO];
    assign unused_bits = ^cat;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        shf_slice4 u_slice (
            .din  (pre[4*s+6 : 4*s+3]),
            .link ({pre[4*s], pre[4*s+1], pre[4*s+2]}),
            .sel  (sel),
            .dout (sh[4*s+3 : 4*s])
        );
    end

    // Shared output bus: a disabled bank contributes nothing.
    assign bus = en ? sh : '0;
endmodule

// File: rtl/shf_wide_top.sv
module shf_wide_top
    import shf_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic [W-1:0]  data_in,
    input  logic [AW-1:0] amount,
    input  logic [1:0]    mode,
    input  logic          dir_down,
    output logic [W-1:0]  data_out
);
    localparam int NB = 1 << (AW - 2);
    localparam int FW = 4 * NB - 1;

    fill_src_e    src;
    logic [W-1:0]  fwd;
    logic [W-1:0]  up_res;
    logic [FW-1:0] lowfill;
    logic [NB-1:0] bank_en;
    logic [W-1:0]  bank_bus [NB];

    assign src = resolve_fill(fill_mode_e'(mode), dir_down);

    // Orientation: downward shifts run through the upward path bit-reversed.
    for (genvar i = 0; i < W; i++) begin : g_orient
        assign fwd[i]      = dir_down ? data_in[W-1-i] : data_in[i];
        assign data_out[i] = dir_down ? up_res[W-1-i]  : up_res[i];
    end

    shf_fill #(.W(W), .FW(FW)) u_fill (
        .word     (fwd),
        .sign_bit (data_in[W-1]),
        .src      (src),
        .lowfill  (lowfill)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_en[b] = (amount[AW-1:2] == (AW-2)'(b));
        shf_bank #(.W(W), .FW(FW), .B(b)) u_bank (
            .word    (fwd),
            .lowfill (lowfill),
            .sel     (amount[1:0]),
            .en      (bank_en[b]),
            .bus     (bank_bus[b])
        );
    end

    always_comb begin
        up_res = '0;
        for (int b = 0; b < NB; b++) begin
            up_res = up_res | bank_bus[b];
        end
    end
endmodule

// File: rtl/shf_wide_chk.sv
module shf_wide_chk #(
    parameter int W  = 16,
    parameter int AW = 4,
    parameter int NB = 4
) (
    input logic [W-1:0]  data_in,
    input logic [AW-1:0] amount,
    input logic [1:0]    mode,
    input logic          dir_down,
    input logic [W-1:0]  data_out,
    input logic [NB-1:0] bank_en
);
    always_comb begin
        if (!$isunknown({data_in, amount, mode, dir_down})) begin
            AST_ONE_BANK: assert ($countones(bank_en) == 1);  // R8
            AST_BANK_MATCH: assert (bank_en[amount[AW-1:2]]);  // R8
            AST_NO_SHIFT_ID: assert (amount != '0 || data_out == data_in);  // R7
            AST_ROT_POP: assert (mode != 2'b10 || $countones(data_out) == $countones(data_in));  // R5
            AST_ARITH_SIGN: assert (!(mode == 2'b01 && dir_down) || data_out[W-1] == data_in[W-1]);  // R3
            AST_LOW_ZERO: assert (!(mode == 2'b00 && !dir_down && amount != '0) || !data_out[0]);  // R1
            AST_HIGH_ZERO: assert (!(mode == 2'b00 && dir_down && amount != '0) || !data_out[W-1]);  // R2
        end
    end
endmodule

bind shf_wide_top shf_wide_chk #(.W(W), .AW(AW), .NB(NB)) u_chk (
    .data_in  (data_in),
    .amount   (amount),
    .mode     (mode),
    .dir_down (dir_down),
    .data_out (data_out),
    .bank_en  (bank_en)
);

// File: tb/shf_wide_top_tb_top.sv
module shf_wide_top_tb_top;
    localparam int W  = 16;
    localparam int AW = 4;

    typedef struct packed {
        logic [15:0] d;
        logic [3:0]  a;
        logic [1:0]  m;
        logic        dn;
        logic [15:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 4'd4,  2'b00, 1'b0, 16'h2340, 8'd1},  // R1 bank 1
        '{16'h8421, 4'd1,  2'b00, 1'b0, 16'h0842, 8'd1},  // R1 bank 0
        '{16'hF0F0, 4'd15, 2'b00, 1'b1, 16'h0001, 8'd2},  // R2 max amount
        '{16'h8000, 4'd3,  2'b01, 1'b1, 16'hF000, 8'd3},  // R3 negative
        '{16'h7000, 4'd2,  2'b01, 1'b1, 16'h1C00, 8'd3},  // R3 positive
        '{16'h8001, 4'd5,  2'b01, 1'b0, 16'h0020, 8'd4},  // R4
        '{16'h8421, 4'd4,  2'b10, 1'b0, 16'h4218, 8'd5},  // R5 up
        '{16'h8421, 4'd4,  2'b10, 1'b1, 16'h1842, 8'd5},  // R5 down
        '{16'h1234, 4'd4,  2'b11, 1'b0, 16'h2340, 8'd6},  // R6 reserved
        '{16'hABCD, 4'd0,  2'b10, 1'b1, 16'hABCD, 8'd7},  // R7
        '{16'h8001, 4'd3,  2'b10, 1'b0, 16'h000C, 8'd8}   // R8 bank 0 edge
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0]  data_in  = '0;
    logic [AW-1:0] amount   = '0;
    logic [1:0]    mode     = '0;
    logic          dir_down = 1'b0;
    logic [W-1:0]  data_out;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    shf_wide_top #(.W(W), .AW(AW)) dut_i (
        .data_in  (data_in),
        .amount   (amount),
        .mode     (mode),
        .dir_down (dir_down),
        .data_out (data_out)
    );

    function automatic logic [W-1:0] ref_shift(logic [W-1:0] d, int a, logic [1:0] m, logic dn);
        logic [W-1:0] r;
        if (m == 2'b10) begin
            for (int i = 0; i < W; i++) begin
                r[i] = dn ? d[(i + a) % W] : d[(i - a + W) % W];
            end
        end else if (m == 2'b01 && dn) begin
            r = W'($signed(d) >>> a);
        end else begin
            r = dn ? (d >> a) : (d << a);
        end
        return r;
    endfunction

    task automatic apply(logic [W-1:0] d, int a, logic [1:0] m, logic dn);
        data_in  = d;
        amount   = AW'(a);
        mode     = m;
        dir_down = dn;
        #2;
    endtask

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (amt %0d mode %b down %b)",
                     req, got, exp, amount, mode, dir_down);
        end
    endtask

    task automatic run_all();
        // Reset phase: all-zero inputs give an all-zero word (R7).
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset", data_out, '0);
        rst = 1'b0;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].d, int'(VECS[v].a), VECS[v].m, VECS[v].dn);
            check($sformatf("R%0d table %0d", VECS[v].req, v), data_out, VECS[v].e);
        end

        // Full sweep: every mode code, direction, amount; mixed data (R1 R2 R3 R4 R5 R6 R8)
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] d;
            case (k)
                0: d = 16'h8000;
                1: d = 16'h0001;
                2: d = 16'hFFFF;
                default: d = W'($urandom);
            endcase
            for (int m = 0; m < 4; m++) begin
                for (int dn = 0; dn < 2; dn++) begin
                    for (int a = 0; a < (1 << AW); a++) begin
                        apply(d, a, 2'(m), 1'(dn));
                        check($sformatf("R%0d sweep", (m == 3) ? 6 : (m == 2) ? 5 :
                                        (m == 1) ? (dn ? 3 : 4) : (dn ? 2 : 1)),
                              data_out, ref_shift(d, a, 2'(m), 1'(dn)));
                    end
                end
            end
        end

        // Corners: amount 0 identity in all modes (R7), bank boundaries 3/4 and 11/12 (R8)
        for (int m = 0; m < 4; m++) begin
            apply(16'hC35A, 0, 2'(m), 1'b1);
            check("R7 zero amount", data_out, 16'hC35A);
        end
        apply(16'h0001, 3, 2'b00, 1'b0);
        check("R8 amount 3", data_out, 16'h0008);
        apply(16'h0001, 4, 2'b00, 1'b0);
        check("R8 amount 4", data_out, 16'h0010);
        apply(16'h0001, 11, 2'b00, 1'b0);
        check("R8 amount 11", data_out, 16'h0800);
        apply(16'h0001, 12, 2'b00, 1'b0);
        check("R8 amount 12", data_out, 16'h1000);
        apply(16'h8001, 15, 2'b10, 1'b0);
        check("R5 rotate 15 up", data_out, 16'hC000);
        apply(16'h8000, 15, 2'b01, 1'b1);
        check("R3 sign full", data_out, 16'hFFFF);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule